// File: doc/BRIEF.md
# GPIO Port Controller with Edge-Capture Interrupts

This block controls one general-purpose I/O port of up to `NPINS` pins through a small register bus. The bus has an address, write data, a write strobe and a combinational read-data return. Software sets which pins drive, which pins are observed, and the output levels. The output levels can be loaded whole, or changed one bit at a time through dedicated set, clear and invert registers, so no read-modify-write is needed.

Each observed pin passes through a two-flop synchronizer. A per-pin polarity bit then chooses whether a rising or a falling transition is captured. A captured transition sets a sticky status bit, and software clears that bit by writing 1 to it. The status word is masked by two independent enable words to drive two level interrupt lines, A and B. This lets different pins be routed to different interrupt handlers.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads 0, `pad_out` and `pad_oe` are 0, and both interrupt lines are low.
- R2: Register offsets: 0 drive-enable, 1 sense-enable, 2 output level, 3 set, 4 clear, 5 invert, 6 polarity, 7 status, 8 mask A, 9 mask B. Any other offset reads 0. A write to offset 2 loads the output level, which appears on `pad_out` and reads back on the next cycle. `pad_oe` follows the drive-enable register.
- R3: Writing to offset 3 drives the 1-bits of the data high, offset 4 drives them low, and offset 5 inverts them. Bits written as 0 leave their outputs unchanged. Reading offsets 3 to 5 returns the current output level.
- R4: For pin i, polarity bit i = 0 captures a falling transition and polarity bit i = 1 captures a rising transition. The opposite transition sets nothing. A pad change made before clock edge k shows in status bit i after edge k+2.
- R5: A pin whose sense-enable bit is 0 never sets its status bit.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: If a captured transition and a clearing write reach the same status bit in the same cycle, the bit stays 1.
- R8: `irq_a` is high exactly when some status bit is 1 and its mask A bit is 1. `irq_b` follows the same rule with mask B. Both lines stay high until the enabled status bits are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | NPINS | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | NPINS | Read data for `bus_addr`, combinational |
| pad_in | input | NPINS | Pad levels, asynchronous |
| pad_out | output | NPINS | Output level per pin |
| pad_oe | output | NPINS | Drive enable per pin |
| irq_a | output | 1 | Interrupt line A, active-high level |
| irq_b | output | 1 | Interrupt line B, active-high level |

## Verification
The assertions assume that `bus_we` is a clean one-cycle strobe carrying a settled address and data. They also assume that `pad_in` is at least stable across the synchronizer, so that the status word can only gain bits on pins that were enabled for sensing in the previous cycle. The bench changes bus inputs and pads only at falling clock edges. It holds every pad level for at least four cycles before the next change, so each transition is seen exactly once. It keeps the pads at 0 through reset, so no transition is captured when reset is released.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_DRIVE  = 4'd0,
        RA_SENSE  = 4'd1,
        RA_LEVEL  = 4'd2,
        RA_SET    = 4'd3,
        RA_CLR    = 4'd4,
        RA_INV    = 4'd5,
        RA_POL    = 4'd6,
        RA_STAT   = 4'd7,
        RA_MASK_A = 4'd8,
        RA_MASK_B = 4'd9
    } reg_addr_e;

    typedef enum logic [1:0] {
        OUT_LOAD,
        OUT_SET,
        OUT_CLR,
        OUT_INV
    } out_op_e;

    typedef struct packed {
        logic      hit;
        out_op_e   op;
    } out_cmd_t;

    function automatic logic wr_hit(input logic we, input logic [ADDR_W-1:0] addr,
                                    input reg_addr_e target);
        return we && (addr == target);
    endfunction

    function automatic out_cmd_t decode_out(input logic we, input logic [ADDR_W-1:0] addr);
        out_cmd_t c;
        c.hit = we;
        c.op  = OUT_LOAD;
        case (addr)
            RA_LEVEL: c.op = OUT_LOAD;
            RA_SET:   c.op = OUT_SET;
            RA_CLR:   c.op = OUT_CLR;
            RA_INV:   c.op = OUT_INV;
            default:  c.hit = 1'b0;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int NPINS  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pad_in,
    input  logic [NPINS-1:0] sense_en,
    input  logic [NPINS-1:0] pol_rise,
    output logic [NPINS-1:0] edge_hit
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [STAGES:0] shift_q;
        logic            cur, prev, rise, fall;

        always_ff @(posedge clk) begin
            if (rst) shift_q <= '0;
            else     shift_q <= {shift_q[STAGES-1:0], pad_in[i]};
        end

        assign cur  = shift_q[STAGES-1];
        assign prev = shift_q[STAGES];
        assign rise = cur & ~prev;
        assign fall = ~cur & prev;
        assign edge_hit[i] = sense_en[i] & (pol_rise[i] ? rise : fall);
    end
endmodule

// File: rtl/gpio_out_ctrl.sv
module gpio_out_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  out_cmd_t         cmd,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] level
);
    logic [NPINS-1:0] level_q, level_d;

    always_comb begin
        level_d = level_q;
        if (cmd.hit) begin
            case (cmd.op)
                OUT_LOAD: level_d = wdata;
                OUT_SET:  level_d = level_q | wdata;
                OUT_CLR:  level_d = level_q & ~wdata;
                OUT_INV:  level_d = level_q ^ wdata;
                default:  level_d = level_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= '0;
        else     level_q <= level_d;
    end

    assign level = level_q;
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] edge_hit,
    input  logic             clr_en,
    input  logic [NPINS-1:0] clr_bits,
    input  logic [NPINS-1:0] mask_a,
    input  logic [NPINS-1:0] mask_b,
    output logic [NPINS-1:0] status,
    output logic             irq_a,
    output logic             irq_b
);
    logic [NPINS-1:0] stat_q, clr_v;

    assign clr_v = clr_en ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_v) | edge_hit;
    end

    assign status = stat_q;
    assign irq_a  = |(stat_q & mask_a);
    assign irq_b  = |(stat_q & mask_b);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_a,
    output logic              irq_b
);
    logic [NPINS-1:0] drive_q, sense_q, pol_q, mask_a_q, mask_b_q;
    logic [NPINS-1:0] level, status, edge_hit;
    out_cmd_t         out_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q  <= '0;
            sense_q  <= '0;
            pol_q    <= '0;
            mask_a_q <= '0;
            mask_b_q <= '0;
        end else begin
            if (wr_hit(bus_we, bus_addr, RA_DRIVE))  drive_q  <= bus_wdata;
            if (wr_hit(bus_we, bus_addr, RA_SENSE))  sense_q  <= bus_wdata;
            if (wr_hit(bus_we, bus_addr, RA_POL))    pol_q    <= bus_wdata;
            if (wr_hit(bus_we, bus_addr, RA_MASK_A)) mask_a_q <= bus_wdata;
            if (wr_hit(bus_we, bus_addr, RA_MASK_B)) mask_b_q <= bus_wdata;
        end
    end

    assign out_cmd = decode_out(bus_we, bus_addr);

    gpio_out_ctrl #(.NPINS(NPINS)) u_out (
        .clk(clk), .rst(rst), .cmd(out_cmd), .wdata(bus_wdata), .level(level)
    );

    gpio_edge_detect #(.NPINS(NPINS), .STAGES(2)) u_edge (
        .clk(clk), .rst(rst), .pad_in(pad_in), .sense_en(sense_q),
        .pol_rise(pol_q), .edge_hit(edge_hit)
    );

    gpio_irq_status #(.NPINS(NPINS)) u_stat (
        .clk(clk), .rst(rst), .edge_hit(edge_hit),
        .clr_en(wr_hit(bus_we, bus_addr, RA_STAT)), .clr_bits(bus_wdata),
        .mask_a(mask_a_q), .mask_b(mask_b_q), .status(status),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    always_comb begin
        case (bus_addr)
            RA_DRIVE:  bus_rdata = drive_q;
            RA_SENSE:  bus_rdata = sense_q;
            RA_LEVEL,
            RA_SET,
            RA_CLR,
            RA_INV:    bus_rdata = level;
            RA_POL:    bus_rdata = pol_q;
            RA_STAT:   bus_rdata = status;
            RA_MASK_A: bus_rdata = mask_a_q;
            RA_MASK_B: bus_rdata = mask_b_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign pad_out = level;
    assign pad_oe  = drive_q;
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
    parameter int NPINS = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       bus_addr,
    input logic [NPINS-1:0] bus_wdata,
    input logic             bus_we,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic             irq_a,
    input logic             irq_b,
    input logic [NPINS-1:0] status,
    input logic [NPINS-1:0] edge_hit,
    input logic [NPINS-1:0] sense_q
);
    // R2: a drive-enable write shows on the pads next cycle
    assert_drive_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 4'd0) |=> (pad_oe == $past(bus_wdata)));

    // R3: set write forces the written ones high
    assert_set_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 4'd3) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)));

    // R3: clear write forces the written ones low
    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 4'd4) |=> ((pad_out & $past(bus_wdata)) == '0));

    // R5: new status bits appear only on sensed pins
    assert_sense_gate_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((status & ~$past(status)) & ~$past(sense_q)) == '0));

    // R7: a captured transition always lands, even against a clear
    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (|edge_hit) |=> ((status & $past(edge_hit)) == $past(edge_hit)));

    // R8: an interrupt line implies a pending status bit
    assert_irq_a_src_R8: assert property (@(posedge clk) disable iff (rst)
        irq_a |-> (status != '0));
    assert_irq_b_src_R8: assert property (@(posedge clk) disable iff (rst)
        irq_b |-> (status != '0));
endmodule

bind gpio_port gpio_port_checker #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .pad_out(pad_out), .pad_oe(pad_oe), .irq_a(irq_a),
    .irq_b(irq_b), .status(status), .edge_hit(edge_hit), .sense_q(sense_q)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe;
    logic          irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port #(.NPINS(N)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_a(irq_a), .irq_b(irq_b)
    );

    // vector: [36] read, [35:32] offset, [31:16] data, [15:0] expected
    localparam int NV = 16;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 4'd2, 16'h00F0, 16'h0000},  // R2 load level
        {1'b1, 4'd2, 16'h0000, 16'h00F0},
        {1'b0, 4'd3, 16'h0003, 16'h0000},  // R3 set
        {1'b1, 4'd2, 16'h0000, 16'h00F3},
        {1'b0, 4'd4, 16'h0030, 16'h0000},  // R3 clear
        {1'b1, 4'd2, 16'h0000, 16'h00C3},
        {1'b0, 4'd5, 16'h0101, 16'h0000},  // R3 invert
        {1'b1, 4'd2, 16'h0000, 16'h01C2},
        {1'b1, 4'd3, 16'h0000, 16'h01C2},  // R3 readback
        {1'b1, 4'd5, 16'h0000, 16'h01C2},
        {1'b0, 4'd0, 16'hA5A5, 16'h0000},  // R2 drive enable
        {1'b1, 4'd0, 16'h0000, 16'hA5A5},
        {1'b0, 4'd6, 16'h1234, 16'h0000},
        {1'b1, 4'd6, 16'h0000, 16'h1234},
        {1'b1, 4'd12, 16'h0000, 16'h0000}, // R2 unused offset
        {1'b1, 4'd7, 16'h0000, 16'h0000}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [N-1:0] exp, input string req);
        bus_addr = a;
        #0.5;
        check(bus_rdata == exp, req, 32'(bus_rdata), 32'(exp));
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 10; a++) rd(4'(a), '0, "R1");
        check(pad_out == '0 && pad_oe == '0, "R1", 32'({pad_out, pad_oe}), 0);
        check(!irq_a && !irq_b, "R1", 32'({irq_a, irq_b}), 0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][36]) rd(VEC[v][35:32], VEC[v][15:0], "R2/R3 vector");
            else            wr(VEC[v][35:32], VEC[v][31:16]);
        end
        check(pad_out == 16'h01C2, "R2", 32'(pad_out), 32'h01C2);
        check(pad_oe == 16'hA5A5, "R2", 32'(pad_oe), 32'hA5A5);

        // edge capture: pin0 falling, pin1 rising, pin2 not sensed
        wr(4'd6, 16'h0002);
        wr(4'd1, 16'h0003);
        @(negedge clk); pad_in[1] = 1'b1;
        @(negedge clk); rd(4'd7, 16'h0000, "R4 latency before");
        @(negedge clk); rd(4'd7, 16'h0000, "R4 latency before");
        @(negedge clk); rd(4'd7, 16'h0002, "R4 rising captured");
        pad_in[0] = 1'b1; settle();
        rd(4'd7, 16'h0002, "R4 opposite edge ignored");
        pad_in[0] = 1'b0; settle();
        rd(4'd7, 16'h0003, "R4 falling captured");
        pad_in[2] = 1'b1; settle(); pad_in[2] = 1'b0; settle();
        rd(4'd7, 16'h0003, "R5 unsensed pin");

        // interrupt routing
        check(!irq_a && !irq_b, "R8 masks clear", 32'({irq_a, irq_b}), 0);
        wr(4'd8, 16'h0001);
        check(irq_a && !irq_b, "R8 mask A", 32'({irq_a, irq_b}), 2);
        wr(4'd9, 16'h0002);
        check(irq_a && irq_b, "R8 mask B", 32'({irq_a, irq_b}), 3);

        // write-1-to-clear
        wr(4'd7, 16'h0000);
        rd(4'd7, 16'h0003, "R6 zero write");
        wr(4'd7, 16'h0001);
        rd(4'd7, 16'h0002, "R6 clear bit0");
        check(!irq_a && irq_b, "R8 A drops after clear", 32'({irq_a, irq_b}), 1);

        // race: pin1 falls (no capture), clear, then rise meets a clear
        pad_in[1] = 1'b0; settle();
        wr(4'd7, 16'h0002);
        rd(4'd7, 16'h0000, "R6 clear bit1");
        check(!irq_b, "R8 B drops after clear", 32'(irq_b), 0);
        @(negedge clk); pad_in[1] = 1'b1;
        @(negedge clk);
        wr(4'd7, 16'h0002);
        rd(4'd7, 16'h0002, "R7 edge beats clear");
        check(irq_b, "R8 B level held", 32'(irq_b), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule